// File: doc/BRIEF.md
# Eight-Bit ALU with Packed Condition Flags

This block is the arithmetic and logic stage of a small accumulator machine. One operand is always the accumulator and the other comes from the register file or an immediate field. The opcode picks one of these operations: add, add with carry, subtract, subtract with borrow, AND, OR, XOR, compare and complement. The 8-bit result is combinational. A write-back strobe tells the surrounding datapath whether that result should be stored.

Five condition flags are computed with the result. They are sign, zero, half carry (the carry out of bit 3, kept for a later decimal correction step), even parity and carry. The flags are captured in a byte-wide register on a clock edge, but only when the flag-write enable is high. The register can also be reloaded in one step from a 16-bit status word popped off the stack. The block always presents the current status word: the accumulator in the high byte and the flags byte in the low byte.

Top module: `flag_alu8`

## Requirements
- R1: Add (opcode 0) gives acc+b. Add with carry (opcode 1) gives acc+b+carry_i. The carry flag is the carry out of bit 7. The half-carry flag is the carry out of bit 3.
- R2: Subtract (opcode 2) gives acc-b. Subtract with borrow (opcode 3) gives acc-b-carry_i. The carry flag is set when the full subtraction borrows. The half-carry flag is set when the low nibble borrows, that is, when acc[3:0] < b[3:0]+borrow.
- R3: AND (opcode 4), OR (opcode 5) and XOR (opcode 6) give the bitwise result. Each of them clears the carry flag. AND sets the half-carry flag. OR and XOR clear it.
- R4: For every flag-writing operation, sign copies result bit 7, zero is set when the result is 0x00, and parity is set when the result holds an even number of ones.
- R5: The flags byte has sign at bit 7, zero at bit 6, half carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5 and 3 always read 0 and bit 1 always reads 1. After reset the flags byte is 0x02.
- R6: Compare (opcode 7) updates the flags exactly as subtract would for the same operands. It drives res_we_o low. Every other opcode drives res_we_o high.
- R7: Complement (opcode 8) outputs ~acc. Opcodes 9 to 15 pass acc through unchanged. Neither group changes the flags register, even when flag_we_i is high.
- R8: When neither flag_we_i nor psw_load_i is high at a clock edge, the flags register keeps its value.
- R9: psw_o is always {acc_i, flags byte}.
- R10: When psw_load_i is high at a clock edge, the flags register loads psw_i[7:0] with the padding bits forced as in R5. This load takes precedence over flag_we_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_i | input | 8 | Accumulator operand |
| opb_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry or borrow in for opcodes 1 and 3 |
| op_i | input | 4 | Operation code |
| flag_we_i | input | 1 | Flag-write enable |
| psw_load_i | input | 1 | Load the flags from a popped status word |
| psw_i | input | 16 | Popped status word (low byte used) |
| result_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result should be written back |
| flags_o | output | 8 | Registered flags byte |
| psw_o | output | 16 | Status word {accumulator, flags} |

## Verification
The arithmetic operations are driven with operand pairs chosen to separate the individual flags. One pair carries out of bit 3 but not bit 7, another carries out of bit 7 but not bit 3, and a third wraps exactly to zero. A further pair borrows only in the low nibble. The carry and borrow inputs are toggled on identical operands, which shows whether carry_i is applied only for opcodes 1 and 3. Logic operations are run with patterns that give odd and even parity, and with a previously set carry flag, to show that carry and half carry are forced by the operation. Compare, complement, pass-through codes, a disabled write and a pop load issued together with a write-enable are placed between known flag states, so that any change they make to the flags byte is visible.

// File: rtl/alu8_pkg.sv
// Package: shared widths, opcode encoding and flag bit positions for the
// eight-bit flag ALU. Assumes every user imports it before use.
package alu8_pkg;
    localparam int DW = 8;
    localparam int NIB = DW / 2;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_CMP = 4'd7,
        OP_CPL = 4'd8
    } alu_op_e;

    // Flag byte bit positions; a neighbour decodes these.
    localparam int FB_SIGN = 7;
    localparam int FB_ZERO = 6;
    localparam int FB_HALF = 4;
    localparam int FB_PAR  = 2;
    localparam int FB_ONE  = 1;
    localparam int FB_CY   = 0;

    localparam logic [DW-1:0] FLAGS_RESET = 8'h02;

    // Pack five flag bits into the byte layout with fixed padding.
    function automatic logic [DW-1:0] pack_flags(
        input logic s, input logic z, input logic h,
        input logic p, input logic c);
        logic [DW-1:0] f;
        f = '0;
        f[FB_SIGN] = s;
        f[FB_ZERO] = z;
        f[FB_HALF] = h;
        f[FB_PAR]  = p;
        f[FB_ONE]  = 1'b1;
        f[FB_CY]   = c;
        return f;
    endfunction
endpackage

// File: rtl/alu8_arith.sv
// Module: adder/subtractor core. Computes a+b+cin or a-b-cin with a
// carry (or borrow) out of the top bit and of the low nibble.
// Assumes cin is already masked to zero for plain add/subtract.
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cy_o,
    output logic         half_o
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   full;
    logic [H:0]   low;

    // Form the two's complement operand for subtraction.
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~cin_i : cin_i;
    end

    // Full-width and low-nibble sums; borrow is the inverted carry.
    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low    = {1'b0, a_i[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
        sum_o  = full[W-1:0];
        cy_o   = sub_i ? ~full[W] : full[W];
        half_o = sub_i ? ~low[H] : low[H];
    end
endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise unit. Produces AND, OR, XOR or complement of the
// accumulator and reports the half-carry value each logic op defines.
// Assumes sel_i uses the package opcode encoding.
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [OPW-1:0] sel_i,
    output logic [W-1:0]   res_o,
    output logic           half_o
);
    // Select the bitwise function; unlisted codes pass a through.
    always_comb begin
        half_o = 1'b0;
        unique case (sel_i)
            OP_AND: begin
                res_o  = a_i & b_i;
                half_o = 1'b1;
            end
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_CPL:  res_o = ~a_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_flagreg.sv
// Module: flags byte register. A pop load wins over a flag write;
// padding bits are forced on every load. Synchronous active-low reset.
module alu8_flagreg
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         load_i,
    input  logic [W-1:0] ldata_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] popped;

    // Re-pack a popped byte so the padding is always canonical.
    always_comb begin
        popped = pack_flags(ldata_i[FB_SIGN], ldata_i[FB_ZERO], ldata_i[FB_HALF],
                            ldata_i[FB_PAR], ldata_i[FB_CY]);
    end

    // Capture flags on reset, pop or write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      flags_o <= FLAGS_RESET;
        else if (load_i) flags_o <= popped;
        else if (we_i)   flags_o <= wdata_i;
    end
endmodule

// File: rtl/flag_alu8.sv
// Module: top of the eight-bit ALU. Routes the opcode to the arithmetic
// or logic unit, builds the five condition flags, and keeps them in a
// register that loads on a flag write or a status-word pop.
// Assumes op_i is stable around the clock edge when a flag write is due.
module flag_alu8
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     acc_i,
    input  logic [W-1:0]     opb_i,
    input  logic             carry_i,
    input  logic [OPW-1:0]   op_i,
    input  logic             flag_we_i,
    input  logic             psw_load_i,
    input  logic [2*W-1:0]   psw_i,
    output logic [W-1:0]     result_o,
    output logic             res_we_o,
    output logic [W-1:0]     flags_o,
    output logic [2*W-1:0]   psw_o
);
    logic         is_arith;
    logic         is_sub;
    logic         is_logic;
    logic         use_cin;
    logic         writes_flags;
    logic [W-1:0] ar_res;
    logic         ar_cy;
    logic         ar_half;
    logic [W-1:0] lg_res;
    logic         lg_half;
    logic         nx_cy;
    logic         nx_half;
    logic [W-1:0] nx_flags;

    // Classify the opcode.
    always_comb begin
        is_arith     = (op_i <= OP_SBB) || (op_i == OP_CMP);
        is_sub       = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
        is_logic     = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);
        use_cin      = (op_i == OP_ADC) || (op_i == OP_SBB);
        writes_flags = is_arith || is_logic;
    end

    alu8_arith #(.W(W)) arith_i (
        .a_i    (acc_i),
        .b_i    (opb_i),
        .cin_i  (carry_i & use_cin),
        .sub_i  (is_sub),
        .sum_o  (ar_res),
        .cy_o   (ar_cy),
        .half_o (ar_half)
    );

    alu8_logic #(.W(W)) logic_i (
        .a_i    (acc_i),
        .b_i    (opb_i),
        .sel_i  (op_i),
        .res_o  (lg_res),
        .half_o (lg_half)
    );

    // Choose the result and the write-back strobe.
    always_comb begin
        result_o = is_arith ? ar_res : lg_res;
        res_we_o = (op_i != OP_CMP);
    end

    // Build the next flags byte from the selected result.
    always_comb begin
        nx_cy    = is_arith ? ar_cy : 1'b0;
        nx_half  = is_arith ? ar_half : lg_half;
        nx_flags = pack_flags(result_o[W-1], (result_o == '0), nx_half,
                              ~(^result_o), nx_cy);
    end

    alu8_flagreg #(.W(W)) flagreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (flag_we_i & writes_flags),
        .wdata_i (nx_flags),
        .load_i  (psw_load_i),
        .ldata_i (psw_i[W-1:0]),
        .flags_o (flags_o)
    );

    // Present the status word.
    always_comb psw_o = {acc_i, flags_o};
endmodule

// File: rtl/flag_alu8_chk.sv
// Module: assertion checker for flag_alu8, attached by bind.
module flag_alu8_chk
    import alu8_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic          flag_we_i,
    input logic          psw_load_i,
    input logic [15:0]   psw_i,
    input logic [7:0]    result_o,
    input logic          res_we_o,
    input logic [7:0]    flags_o
);
    logic wr;
    always_comb wr = flag_we_i && !psw_load_i && (op_i <= OP_CMP);

    AST_PAD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[5] == 1'b0) && (flags_o[3] == 1'b0) && flags_o[1]); // R5
    AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> flags_o[FB_SIGN] == $past(result_o[7])); // R4
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> flags_o[FB_ZERO] == $past(result_o == 8'h00)); // R4
    AST_EVEN_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> flags_o[FB_PAR] == $past(($countones(result_o) % 2) == 0)); // R4
    AST_LOGIC_NOCY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op_i >= OP_AND && op_i <= OP_XOR) |=> !flags_o[FB_CY]); // R3
    AST_CMP_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |-> !res_we_o); // R6
    AST_NOFLAG_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!psw_load_i && op_i >= OP_CPL) |=> $stable(flags_o)); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!psw_load_i && !flag_we_i) |=> $stable(flags_o)); // R8
    AST_POP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        psw_load_i |=> flags_o == {$past(psw_i[7:6]), 1'b0, $past(psw_i[4]),
                                    1'b0, $past(psw_i[2]), 1'b1, $past(psw_i[0])}); // R10
endmodule

bind flag_alu8 flag_alu8_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .flag_we_i  (flag_we_i),
    .psw_load_i (psw_load_i),
    .psw_i      (psw_i),
    .result_o   (result_o),
    .res_we_o   (res_we_o),
    .flags_o    (flags_o)
);

// File: tb/flag_alu8_tb_top.sv
module flag_alu8_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc = '0;
    logic [7:0]  opb = '0;
    logic        cin = 1'b0;
    logic [3:0]  op = '0;
    logic        fwe = 1'b0;
    logic        pload = 1'b0;
    logic [15:0] pin = '0;
    logic [7:0]  res;
    logic        rwe;
    logic [7:0]  flg;
    logic [15:0] psw;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [7:0]  res;
        logic        rwe;
        logic [7:0]  flg;
        logic [15:0] psw;
        string       tag;
    } exp_t;
    exp_t q[$];
    logic [7:0] mflags = 8'h02;

    always #4 clk = ~clk;

    flag_alu8 dut_i (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .opb_i(opb), .carry_i(cin),
        .op_i(op), .flag_we_i(fwe), .psw_load_i(pload), .psw_i(pin),
        .result_o(res), .res_we_o(rwe), .flags_o(flg), .psw_o(psw)
    );

    function automatic logic [7:0] mk(input logic [7:0] r, input logic h, input logic c);
        return {r[7], (r == 8'h00), 1'b0, h, 1'b0, ~(^r), 1'b1, c};
    endfunction

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Driver: apply one operation and push its expected outcome.
    task automatic drive(input string tag, input logic [3:0] o, input logic [7:0] a,
                         input logic [7:0] b, input logic c, input logic we,
                         input logic pl, input logic [15:0] pw);
        exp_t e;
        logic [8:0] wide;
        logic [4:0] nib;
        logic       ci;
        logic [7:0] r;
        logic [7:0] nf;
        @(negedge clk);
        acc = a; opb = b; cin = c; op = o; fwe = we; pload = pl; pin = pw;
        ci = (o == 4'd1 || o == 4'd3) ? c : 1'b0;
        nf = mflags;
        case (o)
            4'd0, 4'd1: begin
                wide = a + b + ci; nib = a[3:0] + b[3:0] + ci;
                r = wide[7:0]; nf = mk(r, nib[4], wide[8]);
            end
            4'd2, 4'd3, 4'd7: begin
                r = a - b - ci;
                nf = mk(r, ({1'b0, a[3:0]} < ({1'b0, b[3:0]} + ci)),
                        ({1'b0, a} < ({1'b0, b} + ci)));
            end
            4'd4: begin r = a & b; nf = mk(r, 1'b1, 1'b0); end
            4'd5: begin r = a | b; nf = mk(r, 1'b0, 1'b0); end
            4'd6: begin r = a ^ b; nf = mk(r, 1'b0, 1'b0); end
            4'd8: r = ~a;
            default: r = a;
        endcase
        if (pl) mflags = {pw[7:6], 1'b0, pw[4], 1'b0, pw[2], 1'b1, pw[0]};
        else if (we && o <= 4'd7) mflags = nf;
        e.res = r; e.rwe = (o != 4'd7); e.flg = mflags; e.psw = {a, mflags}; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: after each edge compare outputs with the oldest item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "result", {8'h00, res}, {8'h00, e.res});
                chk(e.tag, "res_we", {15'h0, rwe}, {15'h0, e.rwe});
                chk(e.tag, "flags", {8'h00, flg}, {8'h00, e.flg});
                chk(e.tag, "psw", psw, e.psw);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R5", "reset flags", {8'h00, flg}, 16'h0002);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: half carry only, full carry only, wrap to zero, carry-in use
        drive("R1", 4'd0, 8'h0F, 8'h01, 1'b1, 1'b1, 1'b0, 16'h0);
        drive("R1", 4'd0, 8'hF0, 8'h20, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R1", 4'd0, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R1", 4'd1, 8'h10, 8'h20, 1'b1, 1'b1, 1'b0, 16'h0);
        drive("R1", 4'd1, 8'h7F, 8'h80, 1'b1, 1'b1, 1'b0, 16'h0);
        // R2: borrow, nibble-only borrow, borrow-in, equal operands
        drive("R2", 4'd2, 8'h10, 8'h20, 1'b1, 1'b1, 1'b0, 16'h0);
        drive("R2", 4'd2, 8'h20, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R2", 4'd3, 8'h05, 8'h05, 1'b1, 1'b1, 1'b0, 16'h0);
        drive("R2", 4'd3, 8'h05, 8'h05, 1'b0, 1'b1, 1'b0, 16'h0);
        // R3/R4: logic ops after a carry was set
        drive("R2", 4'd2, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R3", 4'd4, 8'hF3, 8'h3C, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R3", 4'd5, 8'h80, 8'h01, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R4", 4'd6, 8'hAA, 8'hAA, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R4", 4'd6, 8'h01, 8'h03, 1'b0, 1'b1, 1'b0, 16'h0);
        // R6: compare affects flags only
        drive("R6", 4'd7, 8'h30, 8'h40, 1'b1, 1'b1, 1'b0, 16'h0);
        drive("R6", 4'd7, 8'h42, 8'h42, 1'b0, 1'b1, 1'b0, 16'h0);
        // R7: complement and pass-through leave flags
        drive("R7", 4'd8, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0);
        drive("R7", 4'd12, 8'hC3, 8'h11, 1'b1, 1'b1, 1'b0, 16'h0);
        // R8: no enable, flags hold
        drive("R8", 4'd0, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0, 16'h0);
        // R10: pop load with padding forced, precedence over write
        drive("R10", 4'd0, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1, 16'h12FF);
        drive("R10", 4'd0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 16'h0028);
        // R9: status word follows accumulator
        drive("R9", 4'd8, 8'hA5, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0);
        drive("R5", 4'd2, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 16'h0);
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule